// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block holds the control word of an I2C master and runs the transfer that the word requests. Software writes the control word with enable, master, direction, extended-address, stop and start bits. When a start is requested and allowed, the block asks an abstract byte-level bus for a start condition with the slave address. It then moves one byte at a time through a one-byte transmit holding register or a one-byte receive holding register, counting down a programmed byte count. At the end it either ends the bus transfer, when a stop was requested, or reports access-ready and leaves master mode.

The bus side is a request/done handshake: the block raises `bus_req` with an operation code and holds it until the bus returns `bus_done` with an acknowledge flag and, for reads, a data byte. Status events (NACK, access-ready) leave as one-cycle pulses; transmit-ready and receive-ready leave as levels. Bit timing, slave mode and ten-bit addressing are outside this block. The parameter `LEGACY` selects the older behaviour in which a control write with enable clear resets the whole sequencer.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write stores `ctl_wdata & 16'hcf87` in `ctl_q`; bit 15 is enable, bit 10 master, bit 9 transmit direction, bit 8 extended address, bit 1 stop, bit 0 start. After reset `ctl_q` is 0.
- R2: With `LEGACY`=1, a control write with bit 15 clear forces `ctl_q` to 0, drops any bus request, empties both holding registers and clears `xrdy`; with `LEGACY`=0 the same write only stores the masked word and a running transfer continues.
- R3: A start is acted on only when the written word has enable, master and start set and extended address clear, and the sequencer is idle; otherwise no bus request follows and the stored bits stay as written.
- R4: An accepted start issues `bus_op`=0 with `bus_addr` = `saddr` and `bus_rnw` = inverse of bit 9; a NACK on it gives one `ev_nack` pulse, clears bits 0 and 1 of `ctl_q` and returns to idle.
- R5: An acknowledged start loads `cnt_q` from `cnt_prog`, empties the transmit holding register, clears bit 0 of `ctl_q` and begins the byte transfer.
- R6: Each completed byte decrements `cnt_q`; when `cnt_q` is 0 and stop is set, the block issues `bus_op`=3 (end), and on its completion clears the stop bit, reloads `cnt_q` from `cnt_prog`, empties the transmit holding register and goes idle. A programmed count of 0 goes straight to this check.
- R7: When `cnt_q` is 0 and stop is clear, the block gives one `ev_ardy` pulse, clears bit 10 of `ctl_q` and goes idle.
- R8: In transmit mode a send (`bus_op`=1, byte on `bus_wdata`) is issued only while the transmit holding register is full; `xrdy` is set after an acknowledged start or byte while bytes remain and cleared otherwise; a NACK on a data byte gives `ev_nack`, clears stop and returns to idle.
- R9: `tx_wr` loads the holding register and clears `xrdy` only while it is empty; a write to a full holding register is ignored.
- R10: In receive mode a read (`bus_op`=2) is issued only while the receive holding register is empty; the returned byte appears on `rx_data` with `rrdy`=1 until `rx_pop`.
- R11: `bus_req` and `bus_op` stay steady from the request until the cycle `bus_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_q | output | 16 | Stored control word |
| cnt_prog | input | CNT_W | Programmed byte count |
| cnt_q | output | CNT_W | Bytes remaining in the current transfer |
| saddr | input | 7 | Slave address |
| tx_wr | input | 1 | Transmit holding register write strobe |
| tx_wdata | input | 8 | Transmit byte |
| rx_pop | input | 1 | Empties the receive holding register |
| rx_data | output | 8 | Received byte |
| bus_req | output | 1 | Bus operation requested |
| bus_op | output | 2 | 0 start, 1 send, 2 receive, 3 end |
| bus_addr | output | 7 | Slave address for the start |
| bus_rnw | output | 1 | Read flag for the start |
| bus_wdata | output | 8 | Byte to send |
| bus_done | input | 1 | Bus operation complete |
| bus_ack | input | 1 | Acknowledge of the completed start or send |
| bus_rdata | input | 8 | Byte read by a receive operation |
| xrdy | output | 1 | Transmit holding register wanted |
| rrdy | output | 1 | Received byte held |
| ev_nack | output | 1 | NACK event pulse |
| ev_ardy | output | 1 | Access-ready event pulse |

## Verification
The bench aims at the count edges: a zero programmed count with stop, which a design that decrements before checking would wrap to the top count and send bytes forever, and the last byte, where `xrdy` must fall instead of asking for a byte that will never go out. It writes the transmit register twice in consecutive cycles so that a design that overwrote a full register would send the second byte. It refuses starts with extended address set or master clear, and runs NACKs both on the address and on a data byte; a design that left stop set after a NACK would later issue an end on a bus it does not own. It also holds a received byte unread for several cycles so that a design reading ahead would overwrite it.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int CNT_W  = 8,
  parameter bit LEGACY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [15:0]      ctl_wdata,
  output logic [15:0]      ctl_q,
  input  logic [CNT_W-1:0] cnt_prog,
  output logic [CNT_W-1:0] cnt_q,
  input  logic [6:0]       saddr,
  input  logic             tx_wr,
  input  logic [7:0]       tx_wdata,
  input  logic             rx_pop,
  output logic [7:0]       rx_data,
  output logic             bus_req,
  output logic [1:0]       bus_op,
  output logic [6:0]       bus_addr,
  output logic             bus_rnw,
  output logic [7:0]       bus_wdata,
  input  logic             bus_done,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata,
  output logic             xrdy,
  output logic             rrdy,
  output logic             ev_nack,
  output logic             ev_ardy
);

  localparam logic [15:0] CTL_KEEP = 16'hcf87;
  localparam int B_EN  = 15;
  localparam int B_MST = 10;
  localparam int B_TRX = 9;
  localparam int B_XA  = 8;
  localparam int B_STP = 1;
  localparam int B_STT = 0;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_RUN, S_BYTE, S_STOP} st_t;

  st_t        state;
  logic       rnw_q;
  logic       tx_full, rx_full;
  logic [7:0] tx_byte, wd_q, rx_byte;

  logic go, lrst;
  assign lrst = LEGACY && ctl_wr && !ctl_wdata[B_EN];
  assign go   = ctl_wr && ctl_wdata[B_EN] && ctl_wdata[B_MST] &&
                !ctl_wdata[B_XA] && ctl_wdata[B_STT];

  assign bus_req   = (state == S_START) || (state == S_BYTE) || (state == S_STOP);
  assign bus_op    = (state == S_BYTE) ? (rnw_q ? 2'd2 : 2'd1) :
                     (state == S_STOP) ? 2'd3 : 2'd0;
  assign bus_rnw   = rnw_q;
  assign bus_wdata = wd_q;
  assign rx_data   = rx_byte;
  assign rrdy      = rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n || lrst) begin
      state   <= S_IDLE;
      ctl_q   <= '0;
      cnt_q   <= '0;
      bus_addr <= '0;
      rnw_q   <= 1'b0;
      tx_full <= 1'b0;
      rx_full <= 1'b0;
      tx_byte <= '0;
      wd_q    <= '0;
      rx_byte <= '0;
      xrdy    <= 1'b0;
      ev_nack <= 1'b0;
      ev_ardy <= 1'b0;
    end else begin
      ev_nack <= 1'b0;
      ev_ardy <= 1'b0;
      if (ctl_wr) ctl_q <= ctl_wdata & CTL_KEEP;
      if (rx_pop) rx_full <= 1'b0;
      if (tx_wr && !tx_full) begin
        tx_full <= 1'b1;
        tx_byte <= tx_wdata;
      end
      case (state)
        S_IDLE: if (go) begin
          state    <= S_START;
          bus_addr <= saddr;
          rnw_q    <= !ctl_wdata[B_TRX];
        end
        S_START: if (bus_done) begin
          ctl_q[B_STT] <= 1'b0;
          if (bus_ack) begin
            cnt_q   <= cnt_prog;
            tx_full <= 1'b0;
            xrdy    <= !rnw_q && (cnt_prog != '0);
            state   <= S_RUN;
          end else begin
            ev_nack      <= 1'b1;
            ctl_q[B_STP] <= 1'b0;
            xrdy         <= 1'b0;
            state        <= S_IDLE;
          end
        end
        S_RUN: begin
          if (cnt_q == '0) begin
            if (ctl_q[B_STP]) state <= S_STOP;
            else begin
              ev_ardy      <= 1'b1;
              ctl_q[B_MST] <= 1'b0;
              state        <= S_IDLE;
            end
          end else if (!rnw_q) begin
            if (tx_full) begin
              wd_q    <= tx_byte;
              tx_full <= 1'b0;
              state   <= S_BYTE;
            end
          end else if (!rx_full) begin
            state <= S_BYTE;
          end
        end
        S_BYTE: if (bus_done) begin
          cnt_q <= cnt_q - CNT_ONE;
          if (!rnw_q) begin
            if (bus_ack) begin
              xrdy  <= (cnt_q != CNT_ONE);
              state <= S_RUN;
            end else begin
              xrdy         <= 1'b0;
              ev_nack      <= 1'b1;
              ctl_q[B_STP] <= 1'b0;
              state        <= S_IDLE;
            end
          end else begin
            rx_byte <= bus_rdata;
            rx_full <= 1'b1;
            state   <= S_RUN;
          end
        end
        S_STOP: if (bus_done) begin
          ctl_q[B_STP] <= 1'b0;
          cnt_q        <= cnt_prog;
          tx_full      <= 1'b0;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (tx_wr && !tx_full) xrdy <= 1'b0;
    end
  end

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done && !lrst) |=> (bus_req && $stable(bus_op)));

  a_r6_no_byte_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BYTE) |-> (cnt_q != '0));

  a_r6_stop_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && bus_done && !lrst) |=>
      (cnt_q == $past(cnt_prog) && !ctl_q[B_STP] && !bus_req));

  a_r4_nack_drops_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |-> (!ctl_q[B_STP] && !bus_req));

  a_r7_ardy_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ardy |-> !ctl_q[B_MST]);

  a_r10_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BYTE && rnw_q && bus_done && !lrst) |=> rrdy);

endmodule

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ctl_wr = 0, tx_wr = 0, rx_pop = 0;
  logic [15:0] ctl_wdata = 0;
  logic [7:0]  cnt_prog = 0, tx_wdata = 0;
  logic [6:0]  saddr = 0;
  logic        bus_done = 0, bus_ack = 0;
  logic [7:0]  bus_rdata = 0;

  logic [15:0] ctl_q;
  logic [7:0]  cnt_q, rx_data, bus_wdata;
  logic        bus_req, bus_rnw, xrdy, rrdy, ev_nack, ev_ardy;
  logic [1:0]  bus_op;
  logic [6:0]  bus_addr;

  logic [15:0] ctl_q2;
  logic [7:0]  cnt_q2, rx_data2, bus_wdata2;
  logic        bus_req2, bus_rnw2, xrdy2, rrdy2, ev_nack2, ev_ardy2;
  logic [1:0]  bus_op2;
  logic [6:0]  bus_addr2;

  i2c_xfer_seq #(.CNT_W(8), .LEGACY(1'b1)) dut (
    .clk, .rst_n, .ctl_wr, .ctl_wdata, .ctl_q, .cnt_prog, .cnt_q, .saddr,
    .tx_wr, .tx_wdata, .rx_pop, .rx_data, .bus_req, .bus_op, .bus_addr,
    .bus_rnw, .bus_wdata, .bus_done, .bus_ack, .bus_rdata, .xrdy, .rrdy,
    .ev_nack, .ev_ardy);

  i2c_xfer_seq #(.CNT_W(8), .LEGACY(1'b0)) dut_nl (
    .clk, .rst_n, .ctl_wr, .ctl_wdata, .ctl_q(ctl_q2), .cnt_prog, .cnt_q(cnt_q2),
    .saddr, .tx_wr, .tx_wdata, .rx_pop, .rx_data(rx_data2), .bus_req(bus_req2),
    .bus_op(bus_op2), .bus_addr(bus_addr2), .bus_rnw(bus_rnw2),
    .bus_wdata(bus_wdata2), .bus_done(1'b0), .bus_ack(1'b0), .bus_rdata(8'h00),
    .xrdy(xrdy2), .rrdy(rrdy2), .ev_nack(ev_nack2), .ev_ardy(ev_ardy2));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // bus responder
  bit nack_start = 0, nack_data = 0;
  int lat = 0, rseq = 0;
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      bus_done = 0; lat = 0;
    end else if (bus_done) begin
      bus_done = 0;
    end else if (bus_req) begin
      lat++;
      if (lat >= 2) begin
        lat = 0;
        bus_done = 1;
        bus_ack = (bus_op == 2'd0) ? !nack_start : (bus_op == 2'd1) ? !nack_data : 1'b1;
        if (bus_op == 2'd2) begin
          rseq++;
          bus_rdata = 8'h50 + 8'(rseq);
        end
      end
    end else lat = 0;
  end

  // behavioural reference model
  int m_ph;
  logic [15:0] m_ctl;
  logic [7:0]  m_cnt, m_txb, m_wd, m_rxb;
  logic [6:0]  m_addr;
  bit m_txf, m_rxf, m_xr, m_nk, m_ar, m_rnw;

  always @(posedge clk) begin
    int n_ph;
    logic [15:0] n_ctl;
    logic [7:0] n_cnt, n_txb, n_wd, n_rxb;
    logic [6:0] n_addr;
    bit n_txf, n_rxf, n_xr, n_rnw;
    if (!rst_n || (ctl_wr && !ctl_wdata[15])) begin
      m_ph = 0; m_ctl = 0; m_cnt = 0; m_txb = 0; m_wd = 0; m_rxb = 0; m_addr = 0;
      m_txf = 0; m_rxf = 0; m_xr = 0; m_nk = 0; m_ar = 0; m_rnw = 0;
    end else begin
      n_ph = m_ph; n_ctl = m_ctl; n_cnt = m_cnt; n_txb = m_txb; n_wd = m_wd;
      n_rxb = m_rxb; n_addr = m_addr; n_txf = m_txf; n_rxf = m_rxf; n_xr = m_xr;
      n_rnw = m_rnw;
      m_nk = 0; m_ar = 0;
      if (ctl_wr) n_ctl = ctl_wdata & 16'hcf87;
      if (rx_pop) n_rxf = 0;
      if (tx_wr && !m_txf) begin n_txf = 1; n_txb = tx_wdata; end
      if (m_ph == 0) begin
        if (ctl_wr && ctl_wdata[15] && ctl_wdata[10] && !ctl_wdata[8] && ctl_wdata[0]) begin
          n_ph = 1; n_addr = saddr; n_rnw = !ctl_wdata[9];
        end
      end else if (m_ph == 1) begin
        if (bus_done) begin
          n_ctl[0] = 0;
          if (bus_ack) begin
            n_cnt = cnt_prog; n_txf = 0; n_xr = !m_rnw && (cnt_prog != 0); n_ph = 2;
          end else begin
            m_nk = 1; n_ctl[1] = 0; n_xr = 0; n_ph = 0;
          end
        end
      end else if (m_ph == 2) begin
        if (m_cnt == 0) begin
          if (m_ctl[1]) n_ph = 4;
          else begin m_ar = 1; n_ctl[10] = 0; n_ph = 0; end
        end else if (!m_rnw) begin
          if (m_txf) begin n_wd = m_txb; n_txf = 0; n_ph = 3; end
        end else if (!m_rxf) n_ph = 3;
      end else if (m_ph == 3) begin
        if (bus_done) begin
          n_cnt = m_cnt - 8'd1;
          if (!m_rnw) begin
            if (bus_ack) begin n_xr = (m_cnt != 8'd1); n_ph = 2; end
            else begin n_xr = 0; m_nk = 1; n_ctl[1] = 0; n_ph = 0; end
          end else begin
            n_rxb = bus_rdata; n_rxf = 1; n_ph = 2;
          end
        end
      end else begin
        if (bus_done) begin n_ctl[1] = 0; n_cnt = cnt_prog; n_txf = 0; n_ph = 0; end
      end
      if (tx_wr && !m_txf) n_xr = 0;
      m_ph = n_ph; m_ctl = n_ctl; m_cnt = n_cnt; m_txb = n_txb; m_wd = n_wd;
      m_rxb = n_rxb; m_addr = n_addr; m_txf = n_txf; m_rxf = n_rxf; m_xr = n_xr;
      m_rnw = n_rnw;
    end
  end

  // per-cycle comparison and event capture
  logic [7:0] sent_q[$];
  bit saw_end = 0;
  always @(negedge clk) begin
    bit ereq;
    int eop;
    if (rst_n && !finished) begin
      ereq = (m_ph == 1) || (m_ph == 3) || (m_ph == 4);
      eop  = (m_ph == 3) ? (m_rnw ? 2 : 1) : (m_ph == 4) ? 3 : 0;
      chk(ctl_q == m_ctl, "R1", "ctl_q", ctl_q, m_ctl);
      chk(bus_req == ereq, "R11", "bus_req", bus_req, ereq);
      if (ereq) chk(bus_op == 2'(eop), "R6", "bus_op", bus_op, eop);
      if (m_ph == 1) begin
        chk(bus_addr == m_addr, "R4", "bus_addr", bus_addr, m_addr);
        chk(bus_rnw == m_rnw, "R4", "bus_rnw", bus_rnw, m_rnw);
      end
      if (m_ph == 3 && !m_rnw) chk(bus_wdata == m_wd, "R8", "bus_wdata", bus_wdata, m_wd);
      chk(cnt_q == m_cnt, "R6", "cnt_q", cnt_q, m_cnt);
      chk(xrdy == m_xr, "R8", "xrdy", xrdy, m_xr);
      chk(rrdy == m_rxf, "R10", "rrdy", rrdy, m_rxf);
      if (m_rxf) chk(rx_data == m_rxb, "R10", "rx_data", rx_data, m_rxb);
      chk(ev_nack == m_nk, "R4", "ev_nack", ev_nack, m_nk);
      chk(ev_ardy == m_ar, "R7", "ev_ardy", ev_ardy, m_ar);
      if (bus_req && bus_done && bus_op == 2'd1) sent_q.push_back(bus_wdata);
      if (bus_req && bus_op == 2'd3) saw_end = 1;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(posedge clk); #2; ctl_wr = 1; ctl_wdata = v;
    @(posedge clk); #2; ctl_wr = 0;
  endtask

  task automatic put_tx(input logic [7:0] b);
    @(posedge clk); #2; tx_wr = 1; tx_wdata = b;
    @(posedge clk); #2; tx_wr = 0;
  endtask

  task automatic pop_rx();
    @(posedge clk); #2; rx_pop = 1;
    @(posedge clk); #2; rx_pop = 0;
  endtask

  task automatic wait_xrdy(input string req);
    int t = 0;
    while (!xrdy && t < 200) begin cyc(1); t++; end
    chk(xrdy == 1'b1, req, "xrdy wait", xrdy, 1);
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    while (m_ph != 0 && t < 300) begin cyc(1); t++; end
    cyc(2);
    chk(bus_req == 1'b0, req, "idle", bus_req, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(ctl_q == 16'h0, "R1", "reset ctl_q", ctl_q, 0);
    chk(xrdy == 0 && rrdy == 0, "R1", "reset flags", {xrdy, rrdy}, 0);

    // R1/R3: mask, start refused with extended address
    saddr = 7'h2A; cnt_prog = 8'd3;
    wr_ctl(16'hFFFF);
    cyc(4);
    chk(ctl_q == 16'hcf87, "R1", "masked ctl", ctl_q, 16'hcf87);
    chk(bus_req == 0, "R3", "no start with xa", bus_req, 0);
    // R3: start refused with master clear
    wr_ctl(16'h8001);
    cyc(4);
    chk(bus_req == 0, "R3", "no start without master", bus_req, 0);
    chk(ctl_q == 16'h8001, "R3", "bits kept", ctl_q, 16'h8001);
    // R2 legacy reset
    wr_ctl(16'h0002);
    cyc(1);
    chk(ctl_q == 16'h0, "R2", "legacy disable", ctl_q, 0);

    // transmit, stop, count 3
    sent_q.delete();
    wr_ctl(16'h8603);
    wait_xrdy("R8");
    chk(cnt_q == 8'd3, "R5", "count loaded", cnt_q, 3);
    chk(ctl_q[0] == 1'b0, "R5", "start cleared", ctl_q[0], 0);
    put_tx(8'hA1);
    wait_xrdy("R8");
    put_tx(8'hA2);
    wait_xrdy("R8");
    put_tx(8'hA3);
    wait_idle("R6");
    chk(sent_q.size() == 3, "R8", "bytes sent", sent_q.size(), 3);
    if (sent_q.size() == 3) chk(sent_q[2] == 8'hA3, "R8", "last byte", sent_q[2], 8'hA3);
    chk(ctl_q[1] == 0, "R6", "stop cleared", ctl_q[1], 0);
    chk(cnt_q == 8'd3, "R6", "count reloaded", cnt_q, 3);
    chk(xrdy == 0, "R8", "xrdy low at end", xrdy, 0);

    // R9: overflow write ignored, count 2 no stop -> ardy
    sent_q.delete();
    cnt_prog = 8'd2;
    wr_ctl(16'h8601);
    wait_xrdy("R9");
    @(posedge clk); #2; tx_wr = 1; tx_wdata = 8'h11;
    @(posedge clk); #2; tx_wdata = 8'h22;
    @(posedge clk); #2; tx_wr = 0;
    wait_xrdy("R9");
    put_tx(8'h33);
    wait_idle("R7");
    chk(sent_q.size() == 2, "R9", "sent count", sent_q.size(), 2);
    if (sent_q.size() == 2) begin
      chk(sent_q[0] == 8'h11, "R9", "first kept", sent_q[0], 8'h11);
      chk(sent_q[1] == 8'h33, "R9", "overflow dropped", sent_q[1], 8'h33);
    end
    chk(ctl_q[10] == 0, "R7", "master cleared", ctl_q[10], 0);

    // receive, stop, count 3, slow pops
    cnt_prog = 8'd3;
    wr_ctl(16'h8403);
    for (int k = 1; k <= 3; k++) begin
      int t = 0;
      while (!rrdy && t < 200) begin cyc(1); t++; end
      cyc(4);
      chk(rx_data == 8'h50 + 8'(k), "R10", "rx byte", rx_data, 8'h50 + k);
      pop_rx();
    end
    wait_idle("R10");
    chk(rseq == 3, "R10", "reads issued", rseq, 3);

    // R4: start NACK
    nack_start = 1;
    wr_ctl(16'h8603);
    wait_idle("R4");
    chk(ctl_q[1:0] == 2'b00, "R4", "start/stop cleared", ctl_q[1:0], 0);
    nack_start = 0;

    // R8: data NACK
    nack_data = 1;
    wr_ctl(16'h8603);
    wait_xrdy("R8");
    put_tx(8'h5A);
    wait_idle("R8");
    chk(cnt_q == 8'd2, "R8", "count after data nack", cnt_q, 2);
    chk(ctl_q[1] == 0, "R8", "stop cleared on data nack", ctl_q[1], 0);
    nack_data = 0;

    // R6: zero count with stop
    saw_end = 0;
    cnt_prog = 8'd0;
    wr_ctl(16'h8603);
    wait_idle("R6");
    chk(saw_end == 1, "R6", "end issued at zero count", saw_end, 1);
    chk(xrdy == 0, "R6", "no xrdy at zero count", xrdy, 0);

    // R2: non-legacy instance keeps running after disable
    wr_ctl(16'h0000);
    cyc(1);
    chk(ctl_q == 0 && bus_req == 0, "R2", "legacy idle", {ctl_q, bus_req}, 0);
    chk(ctl_q2 == 16'h0, "R2", "non-legacy stores word", ctl_q2, 0);
    chk(bus_req2 == 1'b1, "R2", "non-legacy keeps request", bus_req2, 1);

    cyc(2);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule